// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block is a one-byte channel from software running on the CPU to an external debugger. The CPU writes a byte through its I/O port. The write also raises a dirty flag, which tells the debugger that fresh data is waiting. The debugger sees the full stored byte and the flag on its own read port. It pulses an acknowledge once it has taken the byte, and the acknowledge drops the flag.

The mailbox shares one I/O address with an ordinary 8-bit I/O register. The CPU reaches the mailbox only when the debug-enable fuse is programmed and the debugger has set its access-enable bit. In every other case the same address reaches the ordinary register. When the CPU reads the mailbox, bit 7 carries the dirty flag in place of the stored MSB, so software can poll whether the debugger has taken the last byte.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the mailbox byte, the dirty flag and the ordinary register are all 0x00/0, and a CPU read through either route returns 0x00.
- R2: A CPU write with the mailbox route active stores `cpu_wdata_i` and sets the dirty flag. Both changes are visible on the debugger port in the cycle after the write.
- R3: A CPU read with the mailbox route active returns the stored bits [6:0] in `cpu_rdata_o[6:0]` and the dirty flag in `cpu_rdata_o[7]`. `cpu_rdata_o` is 0x00 whenever `cpu_sel_i` and `cpu_re_i` are not both high.
- R4: A debugger acknowledge with no mailbox write in the same cycle clears the dirty flag in the next cycle and leaves the stored byte unchanged.
- R5: When a mailbox write and a debugger acknowledge fall in the same cycle, the write wins: the new byte is stored and the flag stays set.
- R6: The mailbox route is active only when `fuse_dbg_en_i` and `dbg_acc_en_i` are both 1. Otherwise a CPU write or read at the shared address reaches the ordinary register, and the mailbox byte and flag are untouched. With `cpu_sel_i` low, a write changes nothing.
- R7: The ordinary register holds its value while the mailbox route is active, including across CPU writes.
- R8: `dbg_data_o` returns all 8 stored bits unchanged, bit 7 included.
- R9: A CPU read has no effect on the dirty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fuse_dbg_en_i | input | 1 | Debug-enable fuse programmed |
| dbg_acc_en_i | input | 1 | Debugger access-enable bit |
| cpu_sel_i | input | 1 | CPU bus selects the shared address |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_re_i | input | 1 | CPU read strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational) |
| dbg_ack_i | input | 1 | Debugger acknowledges it has read the byte |
| dbg_data_o | output | 8 | Stored mailbox byte for the debugger |
| dbg_dirty_o | output | 1 | Dirty flag: new data is waiting |

## Verification
The hardest case to bring about is a mailbox write and a debugger acknowledge landing in the same cycle while the flag is already set. Only in that case does write priority show: a design that lets the acknowledge win looks the same everywhere else. The stimulus sets the flag, drives write and acknowledge together with a new byte, and then reads the flag back through both the debugger port and bit 7 of the CPU read. The route cases are driven with each enable off in turn. After each of these, a read back through the other route shows that the storage that should not have moved still holds its value.

// File: rtl/dmb_pkg.sv
package dmb_pkg;
  typedef enum logic {
    ROUTE_GP   = 1'b0,
    ROUTE_MBOX = 1'b1
  } route_e;
endpackage

// File: rtl/dmb_mbox_store.sv
module dmb_mbox_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              dirty_o
);
  logic [DATA_W-1:0] data_q;
  logic              dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= wdata_i;
      // write has priority over the acknowledge
      if (wr_i)       dirty_q <= 1'b1;
      else if (ack_i) dirty_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign dirty_o = dirty_q;

  AST_WR_SETS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> dirty_o); // R2
  AST_WR_BEATS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ack_i |=> dirty_o && data_o == $past(wdata_i)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !wr_i |=> !dirty_o && $stable(data_o)); // R4
  AST_IDLE_HOLDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !ack_i |=> $stable(dirty_o)); // R9
endmodule

// File: rtl/dmb_gp_store.sv
module dmb_gp_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (wr_i) data_o <= wdata_i;
  end
endmodule

// File: rtl/dmb_route.sv
module dmb_route
  import dmb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              fuse_i,
  input  logic              acc_en_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] mbox_data_i,
  input  logic              dirty_i,
  input  logic [DATA_W-1:0] gp_data_i,
  output logic              mbox_wr_o,
  output logic              gp_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LOW_W = DATA_W - 1;

  route_e route;
  logic [DATA_W-1:0] mbox_view;

  assign route     = (fuse_i && acc_en_i) ? ROUTE_MBOX : ROUTE_GP;
  assign mbox_view = {dirty_i, mbox_data_i[LOW_W-1:0]};
  assign mbox_wr_o = sel_i && we_i && (route == ROUTE_MBOX);
  assign gp_wr_o   = sel_i && we_i && (route == ROUTE_GP);

  always_comb begin
    rdata_o = '0;
    if (sel_i && re_i) rdata_o = (route == ROUTE_MBOX) ? mbox_view : gp_data_i;
  end

  always_comb begin
    AST_ONE_TARGET: assert (!(mbox_wr_o && gp_wr_o)); // R6
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fuse_dbg_en_i,
  input  logic              dbg_acc_en_i,
  input  logic              cpu_sel_i,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              dbg_ack_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic              dbg_dirty_o
);
  localparam int MSB = DATA_W - 1;

  logic              mbox_wr, gp_wr, dirty;
  logic [DATA_W-1:0] mbox_data, gp_data;

  dmb_route #(.DATA_W(DATA_W)) i_route (
    .fuse_i      (fuse_dbg_en_i),
    .acc_en_i    (dbg_acc_en_i),
    .sel_i       (cpu_sel_i),
    .we_i        (cpu_we_i),
    .re_i        (cpu_re_i),
    .mbox_data_i (mbox_data),
    .dirty_i     (dirty),
    .gp_data_i   (gp_data),
    .mbox_wr_o   (mbox_wr),
    .gp_wr_o     (gp_wr),
    .rdata_o     (cpu_rdata_o)
  );

  dmb_mbox_store #(.DATA_W(DATA_W)) i_mbox (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mbox_wr),
    .wdata_i (cpu_wdata_i),
    .ack_i   (dbg_ack_i),
    .data_o  (mbox_data),
    .dirty_o (dirty)
  );

  dmb_gp_store #(.DATA_W(DATA_W)) i_gp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (gp_wr),
    .wdata_i (cpu_wdata_i),
    .data_o  (gp_data)
  );

  assign dbg_data_o  = mbox_data;
  assign dbg_dirty_o = dirty;

  AST_GP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_dbg_en_i && dbg_acc_en_i |=> $stable(gp_data)); // R7
  AST_MBOX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fuse_dbg_en_i && dbg_acc_en_i) && !dbg_ack_i |=> $stable(dbg_data_o) && $stable(dbg_dirty_o)); // R6
  AST_RD_MSB_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_sel_i && cpu_re_i && fuse_dbg_en_i && dbg_acc_en_i |-> cpu_rdata_o[MSB] == dbg_dirty_o); // R3
  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_sel_i && cpu_re_i) |-> cpu_rdata_o == '0); // R3
endmodule

// File: tb/test_dbg_mailbox.sv
module test_dbg_mailbox;
  typedef struct {
    logic [7:0] rdata;
    logic [7:0] ddata;
    logic       dirty;
    string      req;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fuse = 0, acc = 0, sel = 0, we = 0, re = 0, ack = 0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, ddata;
  logic dirty;

  exp_t q[$];
  int checks = 0, failures = 0;
  logic [7:0] m_data = '0, g_data = '0;
  logic m_dirty = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_mailbox i_dbg_mailbox (
    .clk_i(clk), .rst_ni(rst_ni), .fuse_dbg_en_i(fuse), .dbg_acc_en_i(acc),
    .cpu_sel_i(sel), .cpu_we_i(we), .cpu_re_i(re), .cpu_wdata_i(wd),
    .cpu_rdata_o(rdata), .dbg_ack_i(ack), .dbg_data_o(ddata), .dbg_dirty_o(dirty)
  );

  // driver: one bus cycle, expectation describes outputs before the next edge
  task automatic step(input logic f, input logic a, input logic s, input logic w,
                      input logic r, input logic [7:0] d, input logic k, input string req);
    exp_t e;
    logic mb;
    @(negedge clk);
    fuse = f; acc = a; sel = s; we = w; re = r; wd = d; ack = k;
    mb = f & a;
    e.rdata = (s & r) ? (mb ? {m_dirty, m_data[6:0]} : g_data) : 8'h00;
    e.ddata = m_data;
    e.dirty = m_dirty;
    e.req   = req;
    q.push_back(e);
    if (s && w && mb) begin m_data = d; m_dirty = 1'b1; end
    else begin
      if (s && w) g_data = d;
      if (k) m_dirty = 1'b0;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rdata !== e.rdata || ddata !== e.ddata || dirty !== e.dirty) begin
          failures++;
          $display("FAIL %s rdata=%h ddata=%h dirty=%b expected rdata=%h ddata=%h dirty=%b",
                   e.req, rdata, ddata, dirty, e.rdata, e.ddata, e.dirty);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state, both routes
    step(0,0,0,0,0,8'h00,0,"R1 idle");
    step(0,0,1,0,1,8'h00,0,"R1 gp read");
    step(1,1,1,0,1,8'h00,0,"R1 mbox read");
    // R2 write, R8 full byte on debugger port
    step(1,1,1,1,0,8'hA5,0,"R2 write");
    step(1,1,0,0,0,8'h00,0,"R8 dbg byte");
    // R3 read view with msb=dirty, R9 reads keep flag
    step(1,1,1,0,1,8'h00,0,"R3 read dirty");
    step(1,1,1,1,0,8'h3C,0,"R2 write 3C");
    step(1,1,1,0,1,8'h00,0,"R3 msb from flag");
    step(1,1,1,0,1,8'h00,0,"R9 read twice");
    step(1,1,0,0,0,8'h00,0,"R9 flag kept");
    // R4 ack clears, data kept
    step(1,1,1,1,0,8'hC3,0,"R2 write C3");
    step(1,1,0,0,0,8'h00,1,"R4 ack");
    step(1,1,1,0,1,8'h00,0,"R4 cleared read");
    step(1,1,0,0,0,8'h00,1,"R4 ack idle");
    // R5 write and ack together
    step(1,1,1,1,0,8'h11,0,"R5 set");
    step(1,1,1,1,0,8'h96,1,"R5 wr+ack");
    step(1,1,1,0,1,8'h00,0,"R5 flag kept");
    step(1,1,0,0,0,8'h00,1,"R5 clear");
    // R6 route off: fuse off, then access bit off
    step(0,1,1,1,0,8'h5A,0,"R6 fuse off write");
    step(0,1,1,0,1,8'h00,0,"R6 gp read");
    step(1,0,1,1,0,8'h7E,0,"R6 acc off write");
    step(1,0,1,0,1,8'h00,0,"R6 gp read2");
    step(1,1,0,1,0,8'hFF,0,"R6 sel low");
    step(1,1,1,0,1,8'h00,0,"R6 mbox untouched");
    // R7 gp holds across mailbox writes
    step(1,1,1,1,0,8'h81,0,"R7 mbox write");
    step(1,1,1,1,1,8'h42,0,"R7 mbox write2");
    step(0,0,1,0,1,8'h00,0,"R7 gp kept");
    step(1,1,1,0,1,8'h00,0,"R8 R3 final");
    step(0,0,0,0,0,8'h00,0,"R8 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule